// File: doc/BRIEF.md
# Debug Bus Access Comparator

This block watches every cycle on a processor bus and raises a per-comparator match flag when a cycle meets the conditions held in that comparator's registers. The comparison always covers the full address. Each comparator can also be told to accept only reads or only writes, and to check the data byte. The first comparator can invert the data test so that it fires when the byte differs. In tag mode a comparator ignores bus cycles altogether. It matches instead when the opcode at its address reaches the execute stage, which an execute-stage port reports.

Software reaches the comparators through one small register window. A bank register picks the comparator that the window shows. The window then gives that comparator's control byte, its address bytes and its data byte. Match flags are registered and feed a trigger sequencer outside this block.

Top module: `dbgcmp_top`

## Requirements
- R1: After reset the bank register (offset 0x20) and every control, address and data register read 0, so every comparator is disabled and `match` is 0.
- R2: With the enable bit (control bit 0) at 0, a comparator never drives its `match` bit, whatever the bus or execute stage does.
- R3: With direction filtering (control bit 2) at 0, read and write cycles at the programmed address both match.
- R4: With direction filtering at 1, the direction bit (control bit 1) decides which cycles match: 0 accepts only writes (`bus_rnw`=0) and 1 accepts only reads (`bus_rnw`=1). A cycle in the other direction does not match.
- R5: With data checking (control bit 3) at 1, a cycle matches only when the data byte equals the data register. The byte is `bus_wdata` on writes and `bus_rdata` on reads.
- R6: On comparator 0, the invert bit (control bit 4) at 1 makes the data check pass on inequality instead. The bit has effect only while data checking is on.
- R7: On comparators other than 0 the invert bit is not implemented: it reads 0 and writing it has no effect on matching.
- R8: With the tag bit (control bit 5) at 1, bus cycles never match and the direction, data and invert bits are ignored. The comparator matches when `exe_valid` is 1 and `exe_addr` equals its address. Without the tag bit, the execute port is ignored.
- R9: The window shows the comparator selected by bank bits [1:0] at 0x20. The control byte is at 0x28. Address bits [17:16] are at 0x29, bits [15:8] at 0x2A and bits [7:0] at 0x2B. The data byte is at 0x2C. Offsets 0x2D to 0x2F read 0.
- R10: At offset 0x29 only bits [1:0] exist: the other bits read 0 and ignore writes.
- R11: A qualifying cycle sets the comparator's `match` bit in the clock after it, for one cycle only.
- R12: A bank value with no comparator behind it (3 with three comparators) makes the window read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_valid | input | 1 | A bus cycle is present |
| bus_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | ADDR_W | Bus cycle address |
| bus_wdata | input | 8 | Write data bus |
| bus_rdata | input | 8 | Read data bus |
| exe_valid | input | 1 | An opcode enters the execute stage |
| exe_addr | input | ADDR_W | Address of that opcode |
| match | output | NUM_CMP | Registered match pulse per comparator |

## Verification
The properties assume that reset is held for at least two clocks before it is released. Only then do the past-cycle terms of the control bits hold defined values. They also assume that the bus and execute inputs are driven with known levels whenever reset is high. The bench holds reset for several cycles and drives every input to a defined level before release. It changes inputs only on falling edges and parks the bus at idle with zero data between cycles. The tag checks send no execute-stage event while a tagged bus cycle is being probed.

// File: rtl/dbgcmp_pkg.sv
`timescale 1ns/1ps
// Package: shared field layout, window offsets and widths for the
// debug bus comparator. Assumes an 8-bit register port.
package dbgcmp_pkg;
    localparam int REG_W  = 8;
    localparam int BANK_W = 2;
    localparam int CTRL_W = 6;

    // Control byte, MSB first: tag, invert, data check, dir filter, dir, enable.
    typedef struct packed {
        logic tag;
        logic inv;
        logic data_en;
        logic dir_en;
        logic dir_sel;
        logic en;
    } cmp_ctrl_t;

    localparam logic [REG_W-1:0] OFS_BANK = 8'h20;
    localparam logic [REG_W-1:0] OFS_CTRL = 8'h28;
    localparam logic [REG_W-1:0] OFS_AHI  = 8'h29;
    localparam logic [REG_W-1:0] OFS_AMID = 8'h2A;
    localparam logic [REG_W-1:0] OFS_ALO  = 8'h2B;
    localparam logic [REG_W-1:0] OFS_DATA = 8'h2C;

    // Writable control bits: all bits, or all but invert.
    localparam logic [CTRL_W-1:0] MASK_FULL  = 6'h3F;
    localparam logic [CTRL_W-1:0] MASK_NOINV = 6'h2F;
endpackage

// File: rtl/dbgcmp_regs.sv
`timescale 1ns/1ps
// Register file with banked window. Holds the bank select and, per
// comparator, its control, address and data registers. Assumes
// 17 <= ADDR_W <= 24 and NUM_CMP <= 4. Writes through a bank value
// with no comparator behind it are dropped, and reads of it return 0.
module dbgcmp_regs
    import dbgcmp_pkg::*;
#(
    parameter int NUM_CMP = 3,
    parameter int ADDR_W  = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_W-1:0]      reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output cmp_ctrl_t             ctrl_o [NUM_CMP],
    output logic [ADDR_W-1:0]     addr_o [NUM_CMP],
    output logic [REG_W-1:0]      data_o [NUM_CMP],
    output logic [BANK_W-1:0]     bank_o
);
    localparam int HI_W = ADDR_W - 16;

    logic [BANK_W-1:0] bank_q;
    logic              bank_ok;
    logic [BANK_W-1:0] bank_idx;

    // Bank select register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (reg_wr && reg_addr == OFS_BANK)
            bank_q <= reg_wdata[BANK_W-1:0];
    end

    assign bank_o   = bank_q;
    assign bank_ok  = (32'(bank_q) < NUM_CMP);
    assign bank_idx = bank_ok ? bank_q : '0;

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        localparam logic [CTRL_W-1:0] WMASK = (g == 0) ? MASK_FULL : MASK_NOINV;
        cmp_ctrl_t         ctrl_q;
        logic [ADDR_W-1:0] addr_q;
        logic [REG_W-1:0]  data_q;
        logic              sel;

        assign sel = reg_wr && (bank_q == BANK_W'(g));

        // Per-comparator register writes through the window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q <= '0;
                addr_q <= '0;
                data_q <= '0;
            end else if (sel) begin
                case (reg_addr)
                    OFS_CTRL: ctrl_q <= cmp_ctrl_t'(reg_wdata[CTRL_W-1:0] & WMASK);
                    OFS_AHI:  addr_q[ADDR_W-1:16] <= reg_wdata[HI_W-1:0];
                    OFS_AMID: addr_q[15:8] <= reg_wdata;
                    OFS_ALO:  addr_q[7:0] <= reg_wdata;
                    OFS_DATA: data_q <= reg_wdata;
                    default:  ;
                endcase
            end
        end

        assign ctrl_o[g] = ctrl_q;
        assign addr_o[g] = addr_q;
        assign data_o[g] = data_q;
    end

    // Read mux for the bank register and the window.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_BANK) begin
            reg_rdata[BANK_W-1:0] = bank_q;
        end else if (bank_ok) begin
            case (reg_addr)
                OFS_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_o[bank_idx];
                OFS_AHI:  reg_rdata[HI_W-1:0] = addr_o[bank_idx][ADDR_W-1:16];
                OFS_AMID: reg_rdata = addr_o[bank_idx][15:8];
                OFS_ALO:  reg_rdata = addr_o[bank_idx][7:0];
                OFS_DATA: reg_rdata = data_o[bank_idx];
                default:  reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dbgcmp_unit.sv
`timescale 1ns/1ps
// One comparator. Qualifies each bus cycle, or each execute-stage
// opcode in tag mode, against its registers and registers the result.
// Assumes the invert bit is already forced to 0 where it does not exist.
module dbgcmp_unit
    import dbgcmp_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmp_ctrl_t         ctrl,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [REG_W-1:0]  cmp_data,
    input  logic              bus_valid,
    input  logic              bus_rnw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  bus_rdata,
    input  logic              exe_valid,
    input  logic [ADDR_W-1:0] exe_addr,
    output logic              match_q
);
    logic             dir_ok;
    logic             data_ok;
    logic [REG_W-1:0] sample;
    logic             bus_hit;
    logic             exe_hit;
    logic             hit;

    // Qualifiers for a plain bus cycle.
    always_comb begin
        dir_ok  = !ctrl.dir_en || (ctrl.dir_sel == bus_rnw);
        sample  = bus_rnw ? bus_rdata : bus_wdata;
        data_ok = !ctrl.data_en || ((sample == cmp_data) != ctrl.inv);
        bus_hit = bus_valid && !ctrl.tag && (bus_addr == cmp_addr) && dir_ok && data_ok;
        exe_hit = ctrl.tag && exe_valid && (exe_addr == cmp_addr);
        hit     = ctrl.en && (bus_hit || exe_hit);
    end

    // Registered match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_q <= 1'b0;
        else
            match_q <= hit;
    end
endmodule

// File: rtl/dbgcmp_top.sv
`timescale 1ns/1ps
// Debug bus access comparator bank. Joins the banked register file to
// NUM_CMP comparators and gathers their match pulses. Assumes all
// inputs are synchronous to clk.
module dbgcmp_top
    import dbgcmp_pkg::*;
#(
    parameter int NUM_CMP = 3,
    parameter int ADDR_W  = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               bus_valid,
    input  logic               bus_rnw,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic [7:0]         bus_rdata,
    input  logic               exe_valid,
    input  logic [ADDR_W-1:0]  exe_addr,
    output logic [NUM_CMP-1:0] match
);
    cmp_ctrl_t         ctrl  [NUM_CMP];
    logic [ADDR_W-1:0] caddr [NUM_CMP];
    logic [REG_W-1:0]  cdata [NUM_CMP];
    logic [BANK_W-1:0] bank_sel;
    logic [NUM_CMP-1:0] en_v, tag_v, diren_v, dirsel_v;

    dbgcmp_regs #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl_o    (ctrl),
        .addr_o    (caddr),
        .data_o    (cdata),
        .bank_o    (bank_sel)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_unit
        dbgcmp_unit #(.ADDR_W(ADDR_W)) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl      (ctrl[g]),
            .cmp_addr  (caddr[g]),
            .cmp_data  (cdata[g]),
            .bus_valid (bus_valid),
            .bus_rnw   (bus_rnw),
            .bus_addr  (bus_addr),
            .bus_wdata (bus_wdata),
            .bus_rdata (bus_rdata),
            .exe_valid (exe_valid),
            .exe_addr  (exe_addr),
            .match_q   (match[g])
        );
        // Flattened control view for the bound checker.
        assign en_v[g]     = ctrl[g].en;
        assign tag_v[g]    = ctrl[g].tag;
        assign diren_v[g]  = ctrl[g].dir_en;
        assign dirsel_v[g] = ctrl[g].dir_sel;
    end
endmodule

// File: rtl/dbgcmp_chk.sv
`timescale 1ns/1ps
// Checker for dbgcmp_top, attached by bind. Relates the stored control
// bits and the bus inputs to the registered match pulses and the window.
module dbgcmp_chk #(
    parameter int NUM_CMP = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_rnw,
    input logic               exe_valid,
    input logic [7:0]         reg_addr,
    input logic [7:0]         reg_rdata,
    input logic [1:0]         bank_sel,
    input logic [NUM_CMP-1:0] en_v,
    input logic [NUM_CMP-1:0] tag_v,
    input logic [NUM_CMP-1:0] diren_v,
    input logic [NUM_CMP-1:0] dirsel_v,
    input logic [NUM_CMP-1:0] match
);
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_prop
        p_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(en_v[g]) |-> !match[g]);

        p_wrong_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(en_v[g] && !tag_v[g] && diren_v[g] && bus_valid && (bus_rnw != dirsel_v[g]))
            |-> !match[g]);

        p_tag_bus_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(tag_v[g] && !exe_valid) |-> !match[g]);

        if (g > 0) begin : g_noinv
            p_inv_absent_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (bank_sel == 2'(g) && reg_addr == 8'h28) |-> !reg_rdata[4]);
        end
    end

    p_void_bank_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bank_sel) >= NUM_CMP && reg_addr[7:3] == 5'b00101) |-> reg_rdata == 8'h00);
endmodule

bind dbgcmp_top dbgcmp_chk #(.NUM_CMP(NUM_CMP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_rnw   (bus_rnw),
    .exe_valid (exe_valid),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .bank_sel  (bank_sel),
    .en_v      (en_v),
    .tag_v     (tag_v),
    .diren_v   (diren_v),
    .dirsel_v  (dirsel_v),
    .match     (match)
);

// File: tb/tb_dbgcmp_top.sv
`timescale 1ns/1ps
// Bench: a vector table for comparator 0 qualifiers, then directed tests.
module tb_dbgcmp_top;
    localparam int NUM_CMP = 3;
    localparam int ADDR_W  = 18;
    localparam logic [ADDR_W-1:0] A0 = 18'h2_1234;
    localparam logic [ADDR_W-1:0] A1 = 18'h0_0ABC;
    localparam logic [7:0]        D0 = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
    logic bus_valid = 1'b0, bus_rnw = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0, exe_addr = '0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata = 8'h00;
    logic exe_valid = 1'b0;
    logic [NUM_CMP-1:0] match;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dbgcmp_top #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_rnw(bus_rnw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .exe_valid(exe_valid), .exe_addr(exe_addr),
        .match(match)
    );

    // Vector: {req[3:0], ctrl[5:0], addr_hit, rnw, data[7:0], expect}
    localparam int NV = 18;
    localparam logic [20:0] VEC [NV] = '{
        {4'd2, 6'h00, 1'b1, 1'b0, 8'h5A, 1'b0},  // R2 disabled, write
        {4'd2, 6'h00, 1'b1, 1'b1, 8'h5A, 1'b0},  // R2 disabled, read
        {4'd3, 6'h01, 1'b1, 1'b0, 8'h00, 1'b1},  // R3 write matches
        {4'd3, 6'h01, 1'b1, 1'b1, 8'h00, 1'b1},  // R3 read matches
        {4'd3, 6'h01, 1'b0, 1'b1, 8'h00, 1'b0},  // R3 wrong address
        {4'd4, 6'h05, 1'b1, 1'b0, 8'h00, 1'b1},  // R4 writes only: write
        {4'd4, 6'h05, 1'b1, 1'b1, 8'h00, 1'b0},  // R4 writes only: read
        {4'd4, 6'h07, 1'b1, 1'b1, 8'h00, 1'b1},  // R4 reads only: read
        {4'd4, 6'h07, 1'b1, 1'b0, 8'h00, 1'b0},  // R4 reads only: write
        {4'd5, 6'h09, 1'b1, 1'b0, 8'h5A, 1'b1},  // R5 equal on write bus
        {4'd5, 6'h09, 1'b1, 1'b0, 8'h5B, 1'b0},  // R5 differs
        {4'd5, 6'h09, 1'b1, 1'b1, 8'h5A, 1'b1},  // R5 read bus used
        {4'd6, 6'h19, 1'b1, 1'b0, 8'h5A, 1'b0},  // R6 inverted, equal
        {4'd6, 6'h19, 1'b1, 1'b1, 8'h3C, 1'b1},  // R6 inverted, differs
        {4'd6, 6'h11, 1'b1, 1'b0, 8'h3C, 1'b1},  // R6 invert w/o data check
        {4'd5, 6'h0F, 1'b1, 1'b1, 8'h5A, 1'b1},  // R5 read + data
        {4'd4, 6'h0F, 1'b1, 1'b0, 8'h5A, 1'b0},  // R4 write blocked
        {4'd2, 6'h08, 1'b1, 1'b0, 8'h5A, 1'b0}   // R2 enable low, data equal
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] ofs, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ofs; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] ofs, input logic [7:0] exp,
                          input string what);
        @(negedge clk);
        reg_addr = ofs;
        #1;
        chk(req, 32'(reg_rdata), 32'(exp), what);
    endtask

    // One bus cycle; returns the match vector seen in the following clock.
    task automatic bus_cyc(input logic rnw, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                           output logic [NUM_CMP-1:0] m);
        @(negedge clk);
        bus_valid = 1'b1; bus_rnw = rnw; bus_addr = a;
        bus_wdata = rnw ? ~d : d;
        bus_rdata = rnw ? d : ~d;
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = '0; bus_wdata = 8'h00; bus_rdata = 8'h00;
        m = match;
    endtask

    task automatic exe_cyc(input logic [ADDR_W-1:0] a, output logic [NUM_CMP-1:0] m);
        @(negedge clk);
        exe_valid = 1'b1; exe_addr = a;
        @(negedge clk);
        exe_valid = 1'b0; exe_addr = '0;
        m = match;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [NUM_CMP-1:0] m;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1", 32'(match), 0, "match after reset");
        rd_chk("R1", 8'h20, 8'h00, "bank");
        rd_chk("R1", 8'h28, 8'h00, "ctrl");
        rd_chk("R1", 8'h2A, 8'h00, "addr mid");
        rd_chk("R1", 8'h2C, 8'h00, "data");

        // Program comparator 0; R10 high byte keeps only bits [1:0]
        wr_reg(8'h20, 8'h00);
        wr_reg(8'h29, 8'hFE);
        rd_chk("R10", 8'h29, 8'h02, "addr high masked");
        wr_reg(8'h2A, 8'h12);
        wr_reg(8'h2B, 8'h34);
        wr_reg(8'h2C, D0);
        rd_chk("R9", 8'h2B, 8'h34, "addr low");

        // Table walk over comparator 0 qualifiers
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            wr_reg(8'h28, {2'b00, v[16:11]});
            bus_cyc(v[9], v[10] ? A0 : (A0 ^ 18'h1), v[8:1], m);
            chk($sformatf("R%0d", v[20:17]), 32'(m), 32'({2'b00, v[0]}),
                $sformatf("vector %0d", i));
        end

        // R11 single pulse, in the following clock
        wr_reg(8'h28, 8'h01);
        bus_cyc(1'b0, A0, 8'h00, m);
        chk("R11", 32'(m), 32'h1, "pulse after cycle");
        @(negedge clk);
        chk("R11", 32'(match), 32'h0, "pulse drops");

        // R9 bank 1 window and independent match
        wr_reg(8'h28, 8'h00);
        wr_reg(8'h20, 8'h01);
        rd_chk("R9", 8'h20, 8'h01, "bank readback");
        wr_reg(8'h29, 8'h00);
        wr_reg(8'h2A, 8'h0A);
        wr_reg(8'h2B, 8'hBC);
        wr_reg(8'h2C, 8'h33);
        wr_reg(8'h28, 8'h01);
        rd_chk("R9", 8'h2A, 8'h0A, "bank1 addr mid");
        rd_chk("R9", 8'h2D, 8'h00, "reserved offset");
        bus_cyc(1'b1, A1, 8'h00, m);
        chk("R9", 32'(m), 32'h2, "bank1 match");
        bus_cyc(1'b1, A0, 8'h00, m);
        chk("R9", 32'(m), 32'h0, "bank1 other address");

        // R7 invert absent on comparator 1
        wr_reg(8'h28, 8'h19);
        rd_chk("R7", 8'h28, 8'h09, "invert reads 0");
        bus_cyc(1'b0, A1, 8'h33, m);
        chk("R7", 32'(m), 32'h2, "equal data still matches");
        bus_cyc(1'b0, A1, 8'h34, m);
        chk("R7", 32'(m), 32'h0, "unequal data no match");
        wr_reg(8'h28, 8'h01);

        // R8 tag mode on comparator 0
        wr_reg(8'h20, 8'h00);
        wr_reg(8'h28, 8'h3F);
        rd_chk("R8", 8'h28, 8'h3F, "tag ctrl readback");
        bus_cyc(1'b1, A0, 8'h00, m);
        chk("R8", 32'(m), 32'h0, "bus cycle ignored in tag mode");
        exe_cyc(A0, m);
        chk("R8", 32'(m), 32'h1, "execute-stage match");
        exe_cyc(A0 ^ 18'h4, m);
        chk("R8", 32'(m), 32'h0, "execute other address");
        exe_cyc(A1, m);
        chk("R8", 32'(m), 32'h0, "untagged ignores execute");

        // R12 empty bank
        wr_reg(8'h20, 8'h03);
        rd_chk("R12", 8'h28, 8'h00, "empty bank ctrl");
        wr_reg(8'h2C, 8'hAA);
        rd_chk("R12", 8'h2C, 8'h00, "empty bank data");
        wr_reg(8'h20, 8'h00);
        rd_chk("R12", 8'h2C, D0, "bank0 data kept");
        wr_reg(8'h20, 8'h01);
        rd_chk("R12", 8'h2C, 8'h33, "bank1 data kept");
        wr_reg(8'h20, 8'h02);
        rd_chk("R12", 8'h2C, 8'h00, "bank2 data kept");

        // R1 reset again clears state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R1", 8'h20, 8'h00, "bank after re-reset");
        rd_chk("R1", 8'h28, 8'h00, "ctrl after re-reset");
        bus_cyc(1'b1, A0, 8'h00, m);
        chk("R1", 32'(m), 32'h0, "no match after re-reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule